// File: doc/BRIEF.md
# Strap-Selected Configuration Bank Loader

After every reset this block fills a working register file with one of four stored configuration banks. All downstream logic reads its settings from the working registers and never from the stored banks. While reset is held, the block samples a mode strap and two shared pins. A high strap selects pin mode, in which the two pins act as a bank index with the upper pin as the high bit. A low strap is the default when the strap is left unpulled. It selects management mode, in which a bank index fixed by a parameter chooses the power-up bank.

In management mode a host can use a simplified command port to write single working registers or to reload the whole register file from any bank. In pin mode the host port is ignored. A load reads the stored bank through a read port with one cycle of latency. The read port drives a bank memory outside the block. Each load copies one register per clock. A busy flag is high for the whole load, and a one-cycle done pulse marks its end. Host commands that arrive during a load wait until the load is over.

Top module: `cfg_bank_loader`

## Requirements
- R1: While reset is asserted, every working register reads zero on `cfg_o` and `busy_o` is high.
- R2: The strap is captured only while reset is asserted. `mgmt_mode_o` is the inverse of the captured strap, and changes on `strap_i` after reset is released have no effect until the next reset.
- R3: When the captured strap is 1, the power-up load uses bank index {`sel_i[1]`,`sel_i[0]`} as sampled during reset. Changes on `sel_i` after release have no effect.
- R4: When the captured strap is 0, the power-up load uses bank `PRESET_BANK`, whatever the level of `sel_i`.
- R5: A power-up load keeps `busy_o` high for NUM_REGS+2 cycles after reset is released. Working register k (bits k*8 up to k*8+7 of `cfg_o`) then holds word k of the selected bank.
- R6: `done_o` is high for exactly one cycle, which is the first cycle with `busy_o` low after a load.
- R7: In management mode and while idle, a write request is acknowledged in the same cycle on `host_ack_o`. The addressed register shows the new data from the next cycle.
- R8: In pin mode, write and reload requests are never acknowledged and leave `cfg_o` and `busy_o` unchanged.
- R9: Host requests made while `busy_o` is high are not acknowledged. A write held through a load is accepted in the first idle cycle and lands after the load.
- R10: An acknowledged reload of bank b keeps `busy_o` high for NUM_REGS+1 cycles and copies all of bank b. This holds even when b is the bank already loaded, so host edits are overwritten.
- R11: When a reload and a write are requested in the same idle cycle, the reload is taken and the write is not performed.
- R12: Changes in the stored bank contents after a load do not appear on `cfg_o` until the next load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; strap and select pins are sampled while it is low |
| strap_i | input | 1 | Mode strap: 1 selects pin mode, 0 selects management mode |
| sel_i | input | 2 | Shared pins, used as bank select in pin mode |
| host_wr_i | input | 1 | Host register write request, held until acknowledged |
| host_addr_i | input | AW | Host write register index |
| host_wdata_i | input | REG_W | Host write data |
| host_reload_i | input | 1 | Host reload request |
| host_bank_i | input | 2 | Bank index for a reload |
| host_ack_o | output | 1 | High in the cycle a host request is accepted |
| bank_rd_en_o | output | 1 | Bank memory read strobe |
| bank_sel_o | output | 2 | Bank index being read |
| bank_addr_o | output | AW | Word index being read |
| bank_rdata_i | input | REG_W | Read data, valid one cycle after the strobe |
| cfg_o | output | NUM_REGS*REG_W | Flattened working registers |
| busy_o | output | 1 | Load in progress |
| done_o | output | 1 | One-cycle end-of-load pulse |
| mgmt_mode_o | output | 1 | Captured management mode |

## Verification
The bench builds the block with NUM_REGS=16 and PRESET_BANK=2. The short register file keeps each load to a few dozen cycles, so dozens of reloads fit in a random sequence. A preset bank other than zero and other than the pin patterns used can only come from the preset path, which makes a mix-up between preset and pin selection visible. The bank model's contents change with a generation counter, so stale copies and direct reads from the stored banks show up as data mismatches.

// File: rtl/cbl_pkg.sv
// Package: shared types for the configuration bank loader.
// Assumes exactly four stored banks, addressed by a two-bit index.
package cbl_pkg;
    localparam int BANK_COUNT = 4;
    localparam int BANK_IDX_W = $clog2(BANK_COUNT);

    typedef logic [BANK_IDX_W-1:0] bank_idx_t;

    // Loader sequence: boot pick, word copy, final write, idle.
    typedef enum logic [1:0] {
        ST_BOOT  = 2'd0,
        ST_COPY  = 2'd1,
        ST_DRAIN = 2'd2,
        ST_IDLE  = 2'd3
    } ld_state_e;
endpackage

// File: rtl/cbl_mode_latch.sv
// Module: cbl_mode_latch
// Captures the mode strap and the shared select pins on every clock edge
// while reset is held, and freezes them once reset is released. It derives
// the management-mode flag and the bank index for the power-up load.
// Assumes reset is held for at least one clock edge at power-up.
module cbl_mode_latch
    import cbl_pkg::*;
#(
    parameter int PRESET_BANK = 0
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      strap_i,
    input  logic [1:0] sel_i,
    output logic      mgmt_mode_o,
    output bank_idx_t boot_bank_o
);
    logic      strap_q;
    bank_idx_t sel_q;

    // Sample strap and pins only while reset is asserted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strap_q <= strap_i;
            sel_q   <= bank_idx_t'(sel_i);
        end
    end

    assign mgmt_mode_o = !strap_q;
    assign boot_bank_o = strap_q ? sel_q : bank_idx_t'(PRESET_BANK);

    // R2: captured strap never moves after reset release
    p_strap_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(strap_q));
    // R3: captured select pins never move after reset release
    p_sel_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(sel_q));
endmodule

// File: rtl/cbl_copy_seq.sv
// Module: cbl_copy_seq
// Runs the bank-to-register copy. After reset it picks the boot bank,
// reads one word per cycle from the bank memory and writes each word one
// cycle later. When idle in management mode it accepts host writes and
// reloads. A reload takes priority over a write in the same cycle.
// Assumes the bank memory returns data one cycle after the read strobe.
module cbl_copy_seq
    import cbl_pkg::*;
#(
    parameter int NUM_REGS = 32,
    localparam int AW = $clog2(NUM_REGS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mgmt_mode_i,
    input  bank_idx_t     boot_bank_i,
    input  logic          host_wr_i,
    input  logic          host_reload_i,
    input  bank_idx_t     host_bank_i,
    output logic          host_ack_o,
    output logic          host_we_o,
    output logic          rd_en_o,
    output bank_idx_t     rd_bank_o,
    output logic [AW-1:0] rd_addr_o,
    output logic          ld_we_o,
    output logic [AW-1:0] ld_addr_o,
    output logic          busy_o,
    output logic          done_o
);
    localparam logic [AW-1:0] LAST_ADDR = AW'(NUM_REGS - 1);

    ld_state_e     state_q;
    bank_idx_t     cur_bank_q;
    logic [AW-1:0] rd_addr_q;
    logic          ld_we_q;
    logic [AW-1:0] ld_addr_q;
    logic          done_q;
    logic          idle;
    logic          reload_go;
    logic          write_go;

    // Accept host requests only in management mode while idle.
    always_comb begin
        idle      = (state_q == ST_IDLE);
        reload_go = idle && mgmt_mode_i && host_reload_i;
        write_go  = idle && mgmt_mode_i && host_wr_i && !host_reload_i;
    end

    // Sequence the load: boot pick, word reads, drain, idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_BOOT;
            cur_bank_q <= '0;
            rd_addr_q  <= '0;
            done_q     <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_BOOT: begin
                    cur_bank_q <= boot_bank_i;
                    rd_addr_q  <= '0;
                    state_q    <= ST_COPY;
                end
                ST_COPY: begin
                    if (rd_addr_q == LAST_ADDR) state_q <= ST_DRAIN;
                    else rd_addr_q <= rd_addr_q + 1'b1;
                end
                ST_DRAIN: begin
                    state_q <= ST_IDLE;
                    done_q  <= 1'b1;
                end
                ST_IDLE: begin
                    if (reload_go) begin
                        cur_bank_q <= host_bank_i;
                        rd_addr_q  <= '0;
                        state_q    <= ST_COPY;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Delay each read by one cycle to match the bank memory latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_we_q   <= 1'b0;
            ld_addr_q <= '0;
        end else begin
            ld_we_q   <= (state_q == ST_COPY);
            ld_addr_q <= rd_addr_q;
        end
    end

    assign host_ack_o = reload_go || write_go;
    assign host_we_o  = write_go;
    assign rd_en_o    = (state_q == ST_COPY);
    assign rd_bank_o  = cur_bank_q;
    assign rd_addr_o  = rd_addr_q;
    assign ld_we_o    = ld_we_q;
    assign ld_addr_o  = ld_addr_q;
    assign busy_o     = !idle;
    assign done_o     = done_q;

    // R9: no host request is acknowledged during a load
    p_ack_when_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack_o |-> !busy_o);
    // R8: pin mode never acknowledges the host
    p_pin_mode_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !mgmt_mode_i |-> !host_ack_o);
    // R6: done is a single pulse right after busy
    p_done_follows_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));
    p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R5: copy writes step through ascending register indices
    p_copy_ascends_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_we_o && $past(ld_we_o)) |-> (ld_addr_o == $past(ld_addr_o) + 1'b1));
endmodule

// File: rtl/cbl_reg_file.sv
// Module: cbl_reg_file
// The working register file. Each register is cleared by reset and takes
// either a copied bank word or a host write. The two write sources are
// never active together, and the copy path wins if they were.
// Assumes addresses at or above NUM_REGS are simply not stored.
module cbl_reg_file #(
    parameter int NUM_REGS = 32,
    parameter int REG_W    = 8,
    localparam int AW = $clog2(NUM_REGS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ld_we_i,
    input  logic [AW-1:0]             ld_addr_i,
    input  logic [REG_W-1:0]          ld_data_i,
    input  logic                      host_we_i,
    input  logic [AW-1:0]             host_addr_i,
    input  logic [REG_W-1:0]          host_data_i,
    output logic [NUM_REGS*REG_W-1:0] cfg_o
);
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        logic [REG_W-1:0] q;

        // Clear, load or host-write this one working register.
        always_ff @(posedge clk) begin
            if (!rst_n) q <= '0;
            else if (ld_we_i && ld_addr_i == AW'(i)) q <= ld_data_i;
            else if (host_we_i && host_addr_i == AW'(i)) q <= host_data_i;
        end

        assign cfg_o[i*REG_W +: REG_W] = q;
    end

    // R9: host writes and copy writes never overlap
    p_writers_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(ld_we_i && host_we_i));
endmodule

// File: rtl/cfg_bank_loader.sv
// Module: cfg_bank_loader (top)
// Loads one of four stored banks into the working registers after reset.
// The bank is chosen by pins or by a preset, depending on the strap latched
// during reset. In management mode a host may write registers or reload.
// Assumes an external bank memory with one cycle of read latency.
module cfg_bank_loader
    import cbl_pkg::*;
#(
    parameter int NUM_REGS    = 32,
    parameter int REG_W       = 8,
    parameter int PRESET_BANK = 0,
    localparam int AW = $clog2(NUM_REGS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      strap_i,
    input  logic [1:0]                sel_i,
    input  logic                      host_wr_i,
    input  logic [AW-1:0]             host_addr_i,
    input  logic [REG_W-1:0]          host_wdata_i,
    input  logic                      host_reload_i,
    input  logic [1:0]                host_bank_i,
    output logic                      host_ack_o,
    output logic                      bank_rd_en_o,
    output logic [1:0]                bank_sel_o,
    output logic [AW-1:0]             bank_addr_o,
    input  logic [REG_W-1:0]          bank_rdata_i,
    output logic [NUM_REGS*REG_W-1:0] cfg_o,
    output logic                      busy_o,
    output logic                      done_o,
    output logic                      mgmt_mode_o
);
    bank_idx_t     boot_bank;
    bank_idx_t     rd_bank;
    logic          host_we;
    logic          ld_we;
    logic [AW-1:0] ld_addr;

    cbl_mode_latch #(.PRESET_BANK(PRESET_BANK)) u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .strap_i    (strap_i),
        .sel_i      (sel_i),
        .mgmt_mode_o(mgmt_mode_o),
        .boot_bank_o(boot_bank)
    );

    cbl_copy_seq #(.NUM_REGS(NUM_REGS)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .mgmt_mode_i  (mgmt_mode_o),
        .boot_bank_i  (boot_bank),
        .host_wr_i    (host_wr_i),
        .host_reload_i(host_reload_i),
        .host_bank_i  (bank_idx_t'(host_bank_i)),
        .host_ack_o   (host_ack_o),
        .host_we_o    (host_we),
        .rd_en_o      (bank_rd_en_o),
        .rd_bank_o    (rd_bank),
        .rd_addr_o    (bank_addr_o),
        .ld_we_o      (ld_we),
        .ld_addr_o    (ld_addr),
        .busy_o       (busy_o),
        .done_o       (done_o)
    );

    assign bank_sel_o = 2'(rd_bank);

    cbl_reg_file #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .ld_we_i    (ld_we),
        .ld_addr_i  (ld_addr),
        .ld_data_i  (bank_rdata_i),
        .host_we_i  (host_we),
        .host_addr_i(host_addr_i),
        .host_data_i(host_wdata_i),
        .cfg_o      (cfg_o)
    );

    // R1: a load is always running while reset holds
    p_busy_in_reset_r1: assert property (@(posedge clk)
        !rst_n |=> busy_o);
endmodule

// File: tb/test_cfg_bank_loader.sv
module test_cfg_bank_loader;
    localparam int N   = 16;
    localparam int W   = 8;
    localparam int AW  = 4;
    localparam int PRE = 2;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          strap = 1'b0;
    logic [1:0]    sel = 2'b00;
    logic          host_wr_i = 1'b0;
    logic [AW-1:0] host_addr_i = '0;
    logic [W-1:0]  host_wdata_i = '0;
    logic          host_reload_i = 1'b0;
    logic [1:0]    host_bank_i = 2'b00;
    logic          host_ack_o;
    logic          bank_rd_en_o;
    logic [1:0]    bank_sel_o;
    logic [AW-1:0] bank_addr_o;
    logic [W-1:0]  bank_rdata_i = '0;
    logic [N*W-1:0] cfg_o;
    logic          busy_o;
    logic          done_o;
    logic          mgmt_mode_o;

    int gen = 0;
    int checks = 0;
    int errors = 0;
    logic [W-1:0] exp_q [N];

    cfg_bank_loader #(.NUM_REGS(N), .REG_W(W), .PRESET_BANK(PRE)) i_cfg_bank_loader (
        .clk(clk), .rst_n(rst_n), .strap_i(strap), .sel_i(sel),
        .host_wr_i(host_wr_i), .host_addr_i(host_addr_i), .host_wdata_i(host_wdata_i),
        .host_reload_i(host_reload_i), .host_bank_i(host_bank_i), .host_ack_o(host_ack_o),
        .bank_rd_en_o(bank_rd_en_o), .bank_sel_o(bank_sel_o), .bank_addr_o(bank_addr_o),
        .bank_rdata_i(bank_rdata_i), .cfg_o(cfg_o), .busy_o(busy_o), .done_o(done_o),
        .mgmt_mode_o(mgmt_mode_o)
    );

    function automatic logic [W-1:0] bank_val(int b, int a, int g);
        return W'(b * 61 + a * 7 + g * 29 + 13);
    endfunction

    // Bank memory model with one cycle of read latency.
    always_ff @(posedge clk) begin
        if (bank_rd_en_o) bank_rdata_i <= bank_val(int'(bank_sel_o), int'(bank_addr_o), gen);
    end

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run hung, act=expired exp=finished");
        finish_run();
    end

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: act=%0d exp=%0d", req, what, act, exp);
        end
    endtask

    task automatic check_cfg(input string req);
        int bad = -1;
        checks++;
        for (int a = 0; a < N; a++)
            if (bad < 0 && cfg_o[a*W +: W] !== exp_q[a]) bad = a;
        if (bad >= 0) begin
            errors++;
            $display("FAIL %s reg %0d: act=%0d exp=%0d", req, bad, cfg_o[bad*W +: W], exp_q[bad]);
        end
    endtask

    task automatic fill_exp(input int b);
        for (int a = 0; a < N; a++) exp_q[a] = bank_val(b, a, gen);
    endtask

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    // Wait for busy to fall, counting busy cycles, then check the done pulse.
    task automatic wait_load(input int exp_cycles, input string req);
        int cnt = 0;
        while (busy_o && cnt < 1000) begin
            cnt++;
            tick();
        end
        check(cnt == exp_cycles, req, "busy cycles", cnt, exp_cycles);
        check(done_o == 1'b1, "R6", "done at end", int'(done_o), 1);
        tick();
        check(done_o == 1'b0, "R6", "done single", int'(done_o), 0);
    endtask

    task automatic do_reset(input logic s, input logic [1:0] p);
        tick();
        rst_n = 1'b0; strap = s; sel = p;
        host_wr_i = 1'b0; host_reload_i = 1'b0;
        repeat (3) tick();
        for (int a = 0; a < N; a++) exp_q[a] = '0;
        check_cfg("R1");
        check(busy_o == 1'b1, "R1", "busy in reset", int'(busy_o), 1);
        tick();
        rst_n = 1'b1;
        strap = ~s;     // R2: late strap change must not matter
        sel   = ~p;     // R3: late pin change must not matter
        #1;
        wait_load(N + 2, "R5");
        check(mgmt_mode_o == !s, "R2", "mgmt mode", int'(mgmt_mode_o), int'(!s));
    endtask

    task automatic host_write(input logic [AW-1:0] a, input logic [W-1:0] d);
        int cnt = 0;
        host_wr_i = 1'b1; host_addr_i = a; host_wdata_i = d;
        #1;
        while (!host_ack_o && cnt < 1000) begin
            cnt++;
            tick();
        end
        tick();
        host_wr_i = 1'b0;
        exp_q[a] = d;
    endtask

    task automatic host_reload(input logic [1:0] b, input string req);
        host_reload_i = 1'b1; host_bank_i = b;
        #1;
        check(host_ack_o == 1'b1, req, "reload ack", int'(host_ack_o), 1);
        tick();
        host_reload_i = 1'b0;
        wait_load(N + 1, "R10");
        fill_exp(int'(b));
    endtask

    initial begin
        bit ok;
        int cnt;
        void'($urandom(32'd4721));

        // R3: pin mode, bank from pins 01
        do_reset(1'b1, 2'b01);
        fill_exp(1);
        check_cfg("R3");

        // R8: pin mode ignores host writes and reloads
        tick();
        host_wr_i = 1'b1; host_addr_i = 4'd3; host_wdata_i = 8'hA5;
        host_reload_i = 1'b1; host_bank_i = 2'b11;
        ok = 1'b1;
        for (int i = 0; i < 5; i++) begin
            #1;
            if (host_ack_o || busy_o) ok = 1'b0;
            tick();
        end
        host_wr_i = 1'b0; host_reload_i = 1'b0;
        check(ok, "R8", "no ack or busy", int'(ok), 1);
        tick();
        check_cfg("R8");

        // R12: bank content changes do not reach cfg_o
        gen = 1;
        repeat (3) tick();
        check_cfg("R12");

        // R3: pin mode, bank 3 with new content
        do_reset(1'b1, 2'b11);
        fill_exp(3);
        check_cfg("R3");

        // R4: management mode uses the preset bank, not the pins
        do_reset(1'b0, 2'b01);
        fill_exp(PRE);
        check_cfg("R4");

        // R7: host write, acknowledged at once
        host_wr_i = 1'b1; host_addr_i = 4'd5; host_wdata_i = 8'h3C;
        #1;
        check(host_ack_o == 1'b1, "R7", "write ack", int'(host_ack_o), 1);
        tick();
        host_wr_i = 1'b0;
        exp_q[5] = 8'h3C;
        check_cfg("R7");

        // R10: same-bank reload overwrites the host edit
        host_reload(2'(PRE), "R10");
        check_cfg("R10");

        // R9: write during a load is stalled, then lands afterwards
        host_reload_i = 1'b1; host_bank_i = 2'b00;
        #1;
        check(host_ack_o == 1'b1, "R9", "reload ack", int'(host_ack_o), 1);
        tick();
        host_reload_i = 1'b0;
        host_wr_i = 1'b1; host_addr_i = 4'd9; host_wdata_i = 8'h77;
        #1;
        ok = 1'b1;
        cnt = 0;
        while (busy_o && cnt < 1000) begin
            if (host_ack_o) ok = 1'b0;
            cnt++;
            tick();
        end
        check(ok, "R9", "no ack while busy", int'(ok), 1);
        check(host_ack_o == 1'b1, "R9", "ack once idle", int'(host_ack_o), 1);
        tick();
        host_wr_i = 1'b0;
        fill_exp(0);
        exp_q[9] = 8'h77;
        check_cfg("R9");

        // R11: reload beats a coinciding write
        host_wr_i = 1'b1; host_addr_i = 4'd2; host_wdata_i = 8'hEE;
        host_reload_i = 1'b1; host_bank_i = 2'b01;
        #1;
        check(host_ack_o == 1'b1, "R11", "ack", int'(host_ack_o), 1);
        tick();
        host_wr_i = 1'b0; host_reload_i = 1'b0;
        wait_load(N + 1, "R11");
        fill_exp(1);
        check_cfg("R11");

        // Random mix of writes, reloads and content changes (R7, R10, R12)
        for (int it = 0; it < 40; it++) begin
            int op = int'($urandom_range(0, 2));
            if (op == 0) begin
                host_write(AW'($urandom_range(0, N - 1)), W'($urandom));
                check_cfg("R7");
            end else if (op == 1) begin
                host_reload(2'($urandom_range(0, 3)), "R10");
                check_cfg("R10");
            end else begin
                gen = gen + 1;
                tick();
                check_cfg("R12");
            end
        end

        finish_run();
    end
endmodule